// File: doc/BRIEF.md
# Pilot-driven sampling phase tracker

Once acquisition has picked a sampling clock phase and an offset direction, this block keeps that phase coherent through the data symbols of the packet. A pilot-based timing metric arrives once per pilot symbol. The first metric after lock becomes the reference. Each later metric is compared against that reference by a single subtraction. If the new metric has fallen below the reference, the block nudges the phase address by one step in the acquired direction and raises a one-cycle step request. The address wraps around the ring of phases. If the metric has not fallen, nothing moves.

After every step, the next pilot's metric becomes the new reference. A packet-end strobe parks the tracker until acquisition locks again. There is no loop filter and no multiplier: the datapath is one comparator, one incrementer/decrementer and a few registers.

Top module: `phase_tracker`

## Requirements
- R1: After reset, `phase_o` is 0, `step_req_o` is 0 and `step_dir_o` is 0.
- R2: While the tracker is idle (before a lock, or after packet end), pilot strobes change neither `phase_o` nor `step_req_o`.
- R3: When `lock_i` is high in the idle state, `phase_o` takes `init_phase_i` and `step_dir_o` takes `dir_i` on the next clock edge.
- R4: The first pilot after lock only stores its metric as the reference and never causes a step.
- R5: A later pilot whose metric is strictly below the reference raises `step_req_o` in the cycle after the strobe. In the same cycle, `phase_o` moves by one: it increments when `step_dir_o` is 1 and decrements when it is 0.
- R6: A pilot whose metric is greater than the reference leaves `phase_o` unchanged and raises no step.
- R7: A pilot whose metric equals the reference counts as no change.
- R8: The phase address wraps modulo `PHASE_N` (32 by default): stepping up from 31 gives 0, and stepping down from 0 gives 31.
- R9: After a step, the next pilot's metric is reloaded as the reference, and that pilot causes no step.
- R10: `pkt_end_i` returns the tracker to idle and discards the reference, and it takes priority over a pilot in the same cycle. `phase_o` holds its value.
- R11: Pilots that cause no step leave the reference unchanged, so later metrics are still compared with the stored reference and not with the latest pilot.
- R12: `step_req_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_i | input | 1 | Acquisition has locked; starts tracking from idle |
| pkt_end_i | input | 1 | Packet finished; return to idle |
| init_phase_i | input | PHASE_W | Phase address chosen by acquisition |
| dir_i | input | 1 | Offset direction from acquisition (1 = increment) |
| pilot_vld_i | input | 1 | One-cycle strobe, a pilot metric is present |
| metric_i | input | METRIC_W | Pilot timing metric, unsigned |
| phase_o | output | PHASE_W | Current sampling phase address |
| step_req_o | output | 1 | One-cycle phase step request |
| step_dir_o | output | 1 | Direction of steps (1 = increment) |

## Verification
The hardest behaviour to reach from the ports is the state of the stored reference. It is never visible, and it matters only through the step decision of a later pilot. The stimulus exposes it in three ways.

First, it sends a rising metric followed by one that lies between the reference and the latest value, which must not step (R11). Second, right after a step, it sends a metric lower than the old reference, which must not step because it becomes the new reference (R9). Third, it sends a low-metric pilot in the same cycle as packet end, then relocks, which shows that the discarded reference is not reused (R10).

// File: rtl/phase_trk_pkg.sv
package phase_trk_pkg;

    typedef enum logic [1:0] {
        TRK_IDLE  = 2'd0,
        TRK_REF   = 2'd1,
        TRK_TRACK = 2'd2
    } trk_mode_e;

endpackage

// File: rtl/trk_below_ref.sv
// Flags a metric that is strictly below the stored reference, using one subtractor.
module trk_below_ref #(
    parameter int METRIC_W = 12
) (
    input  logic [METRIC_W-1:0] metric_i,
    input  logic [METRIC_W-1:0] ref_i,
    output logic                below_o
);
    localparam int DIFF_W = METRIC_W + 1;

    logic [DIFF_W-1:0] diff;

    assign diff    = {1'b0, metric_i} - {1'b0, ref_i};
    assign below_o = diff[DIFF_W-1];
endmodule

// File: rtl/trk_phase_wrap.sv
// One step up or down on a ring of PHASE_N phase addresses.
module trk_phase_wrap #(
    parameter int PHASE_N = 32,
    parameter int PHASE_W = 5
) (
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               up_i,
    output logic [PHASE_W-1:0] phase_o
);
    localparam logic [PHASE_W-1:0] LAST = PHASE_W'(PHASE_N - 1);

    generate
        if ((1 << PHASE_W) == PHASE_N) begin : g_pow2
            assign phase_o = up_i ? phase_i + 1'b1 : phase_i - 1'b1;
        end else begin : g_cmp
            always_comb begin
                if (up_i) begin
                    phase_o = (phase_i == LAST) ? '0 : phase_i + 1'b1;
                end else begin
                    phase_o = (phase_i == '0) ? LAST : phase_i - 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/phase_tracker.sv
module phase_tracker
    import phase_trk_pkg::*;
#(
    parameter int PHASE_N  = 32,
    parameter int PHASE_W  = $clog2(PHASE_N),
    parameter int METRIC_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lock_i,
    input  logic                pkt_end_i,
    input  logic [PHASE_W-1:0]  init_phase_i,
    input  logic                dir_i,
    input  logic                pilot_vld_i,
    input  logic [METRIC_W-1:0] metric_i,
    output logic [PHASE_W-1:0]  phase_o,
    output logic                step_req_o,
    output logic                step_dir_o
);
    typedef struct packed {
        trk_mode_e             mode;
        logic [PHASE_W-1:0]    phase;
        logic                  dir;
        logic [METRIC_W-1:0]   refm;
        logic                  step;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic               below;
    logic [PHASE_W-1:0] phase_next;

    trk_below_ref #(.METRIC_W(METRIC_W)) u_cmp (
        .metric_i (metric_i),
        .ref_i    (st_q.refm),
        .below_o  (below)
    );

    trk_phase_wrap #(.PHASE_N(PHASE_N), .PHASE_W(PHASE_W)) u_wrap (
        .phase_i (st_q.phase),
        .up_i    (st_q.dir),
        .phase_o (phase_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.step = 1'b0;
        if (pkt_end_i) begin
            st_d.mode = TRK_IDLE;
            st_d.refm = '0;
        end else begin
            case (st_q.mode)
                TRK_IDLE: begin
                    if (lock_i) begin
                        st_d.mode  = TRK_REF;
                        st_d.phase = init_phase_i;
                        st_d.dir   = dir_i;
                    end
                end
                TRK_REF: begin
                    if (pilot_vld_i) begin
                        st_d.refm = metric_i;
                        st_d.mode = TRK_TRACK;
                    end
                end
                TRK_TRACK: begin
                    if (pilot_vld_i && below) begin
                        st_d.phase = phase_next;
                        st_d.step  = 1'b1;
                        st_d.mode  = TRK_REF;
                    end
                end
                default: st_d.mode = TRK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: TRK_IDLE, phase: '0, dir: 1'b0, refm: '0, step: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o    = st_q.phase;
    assign step_req_o = st_q.step;
    assign step_dir_o = st_q.dir;
endmodule

// File: rtl/phase_tracker_chk.sv
module phase_tracker_chk #(
    parameter int PHASE_N = 32,
    parameter int PHASE_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lock_i,
    input logic               pkt_end_i,
    input logic               pilot_vld_i,
    input logic [PHASE_W-1:0] phase_o,
    input logic               step_req_o,
    input logic               step_dir_o
);
    function automatic logic [PHASE_W-1:0] ring_step(input logic [PHASE_W-1:0] p, input logic up);
        if (up) return (int'(p) == PHASE_N - 1) ? '0 : p + 1'b1;
        return (p == '0) ? PHASE_W'(PHASE_N - 1) : p - 1'b1;
    endfunction

    // R12
    step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_req_o |=> !step_req_o);

    // R5
    step_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_req_o |-> ($past(pilot_vld_i) && !$past(pkt_end_i)));

    // R8
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_req_o |-> (phase_o == ring_step($past(phase_o), step_dir_o)));

    // R2
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != $past(phase_o)) |-> (step_req_o || $past(lock_i)));

    // R10
    end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end_i |=> !step_req_o);
endmodule

bind phase_tracker phase_tracker_chk #(.PHASE_N(PHASE_N), .PHASE_W(PHASE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_i      (lock_i),
    .pkt_end_i   (pkt_end_i),
    .pilot_vld_i (pilot_vld_i),
    .phase_o     (phase_o),
    .step_req_o  (step_req_o),
    .step_dir_o  (step_dir_o)
);

// File: tb/tb_phase_tracker.sv
module tb_phase_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_i = 1'b0;
    logic        pkt_end_i = 1'b0;
    logic [4:0]  init_phase_i = '0;
    logic        dir_i = 1'b0;
    logic        pilot_vld_i = 1'b0;
    logic [11:0] metric_i = '0;
    logic [4:0]  phase_o;
    logic        step_req_o;
    logic        step_dir_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    phase_tracker dut (
        .clk, .rst_n, .lock_i, .pkt_end_i, .init_phase_i, .dir_i,
        .pilot_vld_i, .metric_i, .phase_o, .step_req_o, .step_dir_o
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pilot strobe for one cycle; returns sampled just after the registering edge.
    task automatic pilot(input int m);
        @(negedge clk);
        pilot_vld_i = 1'b1;
        metric_i    = 12'(m);
        @(negedge clk);
        pilot_vld_i = 1'b0;
    endtask

    task automatic do_lock(input int ph, input logic d);
        @(negedge clk);
        lock_i       = 1'b1;
        init_phase_i = 5'(ph);
        dir_i        = d;
        @(negedge clk);
        lock_i = 1'b0;
    endtask

    task automatic end_pkt();
        @(negedge clk);
        pkt_end_i = 1'b1;
        @(negedge clk);
        pkt_end_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 phase", phase_o, 0);
        chk("R1 step", step_req_o, 0);
        chk("R1 dir", step_dir_o, 0);
    endtask

    task automatic t_idle();
        pilot(50);
        pilot(10);
        chk("R2 phase", phase_o, 0);
        chk("R2 step", step_req_o, 0);
    endtask

    task automatic t_basic();
        do_lock(10, 1'b1);
        chk("R3 phase", phase_o, 10);
        chk("R3 dir", step_dir_o, 1);
        pilot(100);
        chk("R4 step", step_req_o, 0);
        chk("R4 phase", phase_o, 10);
        pilot(90);
        chk("R5 step", step_req_o, 1);
        chk("R5 phase", phase_o, 11);
        @(negedge clk);
        chk("R12 pulse", step_req_o, 0);
        pilot(50);
        chk("R9 no step", step_req_o, 0);
        chk("R9 phase", phase_o, 11);
        pilot(60);
        chk("R9 vs new ref", step_req_o, 0);
        pilot(49);
        chk("R9 step", step_req_o, 1);
        chk("R9 phase2", phase_o, 12);
        end_pkt();
    endtask

    task automatic t_hold();
        do_lock(5, 1'b0);
        pilot(100);
        pilot(100);
        chk("R7 step", step_req_o, 0);
        chk("R7 phase", phase_o, 5);
        pilot(150);
        chk("R6 step", step_req_o, 0);
        chk("R6 phase", phase_o, 5);
        pilot(120);
        chk("R11 step", step_req_o, 0);
        pilot(99);
        chk("R11 down step", step_req_o, 1);
        chk("R5 down phase", phase_o, 4);
        end_pkt();
    endtask

    task automatic t_wrap();
        do_lock(31, 1'b1);
        pilot(10);
        pilot(9);
        chk("R8 up wrap", phase_o, 0);
        end_pkt();
        do_lock(0, 1'b0);
        pilot(10);
        pilot(9);
        chk("R8 down wrap", phase_o, 31);
        end_pkt();
    endtask

    task automatic t_end();
        do_lock(7, 1'b1);
        pilot(100);
        @(negedge clk);
        pkt_end_i   = 1'b1;
        pilot_vld_i = 1'b1;
        metric_i    = 12'd10;
        @(negedge clk);
        pkt_end_i   = 1'b0;
        pilot_vld_i = 1'b0;
        chk("R10 priority", step_req_o, 0);
        chk("R10 phase", phase_o, 7);
        pilot(1);
        chk("R10 idle", step_req_o, 0);
        chk("R10 hold", phase_o, 7);
        do_lock(7, 1'b1);
        pilot(50);
        chk("R10 fresh ref", step_req_o, 0);
        pilot(40);
        chk("R10 relock step", phase_o, 8);
        end_pkt();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_basic();
        t_hold();
        t_wrap();
        t_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule